// File: doc/BRIEF.md
# Four-Channel Paged DMA Controller

This block is a four-channel DMA engine that a host sets up through a narrow
byte-wide I/O port. Each channel has a 16-bit current address and a 16-bit
remaining-count register. Both are reached through a single port offset, so
two byte accesses are needed for each, and a byte pointer shared by all
channels decides whether an access hits the low or the high byte. Bits 23:16
of the bus address come from a separate per-channel page byte. The page byte
does not move while transfers run, so a transfer stays inside its page.

Once a channel is unmasked, each cycle its request is high it receives one
single-cycle transfer. The block then steps the address up by one unit and the
count down by one. When the count wraps, the block latches a terminal-count
flag and masks the channel again. A channel can instead be put in cascade
mode. Its request is then forwarded upstream and its acknowledge is returned
from upstream, and it drives no address. The build parameter `WORD_MODE`
changes how the host port is decoded and how the bus address is formed.

All host-side and bus-side pins are plain control strobes. There is no
valid/ready flow. A granted transfer always completes in its single cycle,
and a host access is taken in the cycle it is strobed.

Top module: `dma4_ctrl`

## Requirements
- R1: Each channel's address and count are loaded by two byte accesses to one port offset: the first access after the pointer is cleared selects the low byte, the second selects the high byte. Every read or write of any address or count port toggles the shared pointer, and a read returns the byte the pointer selects.
- R2: Any write to the clear-pointer offset (12) resets the shared byte pointer to the low byte, whatever the data.
- R3: Port offsets (in byte mode): address of channel c at 2c, count of channel c at 2c+1, status at 8, single mask at 10, mode at 11, clear-pointer at 12. With `WORD_MODE`=1 the host address is the offset times 2, and accesses at odd host addresses have no effect.
- R4: A mode write selects the channel with bits 1:0. Bits 3:2 give the transfer type: 01 = write to memory (`mem_wr`), 10 = read from memory (`mem_rd`), 00 or 11 = verify (no strobe). Bits 7:6 equal to 11 select cascade; any other value selects single transfers.
- R5: A single-mask write uses bits 1:0 for the channel. Bit 2 = 1 masks the channel and bit 2 = 0 unmasks it. All channels are masked after reset, and a masked channel's request produces no acknowledge.
- R6: An unmasked, non-cascade channel whose request is high at a clock edge receives one transfer. In the following cycle `dack` is one-hot for that channel, and `mem_addr` and the strobe are valid. When several channels request, the lowest channel number wins.
- R7: After each transfer the channel's address increases by one and its count decreases by one.
- R8: A transfer made with a count of 0 sets the channel's terminal-count flag and masks the channel, so a programmed count of N-1 gives exactly N transfers.
- R9: A status read returns the terminal-count flags of channels 0 to 3 in bits 3:0, with bits 7:4 zero, and clears those flags.
- R10: `mem_addr[23:16]` is the channel's page byte. It is never incremented, so a 16-bit address wrapping from FFFF to 0000 stays in the same page.
- R11: With `WORD_MODE`=1, `mem_addr` = {page[7:1], address, 0}: the programmed address counts 16-bit words and a page spans 128 KB.
- R12: For an unmasked cascade channel with its request high, `up_req` is high. `dack` for that channel follows `up_ack` in the same cycle, and `mem_rd` and `mem_wr` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Host write strobe, one access per cycle |
| io_rd | input | 1 | Host read strobe, one access per cycle |
| io_addr | input | 5 | Host port address |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, valid in the cycle `io_rd` is high |
| pg_wr | input | 1 | Page byte write strobe |
| pg_chan | input | 2 | Channel whose page byte is written |
| pg_wdata | input | 8 | Page byte value |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | Per-channel acknowledge |
| mem_addr | output | 24 | Bus address of the current transfer |
| mem_rd | output | 1 | Current transfer reads memory |
| mem_wr | output | 1 | Current transfer writes memory |
| up_req | output | 1 | Forwarded request from cascade channels |
| up_ack | input | 1 | Upstream acknowledge for cascade channels |

## Verification
The hardest states to reach are the ones at the end of a run: the wrap of the
16-bit address inside a page, and a terminal count on one channel while a
lower-numbered channel still holds priority. From the ports these need a long
run of transfers. The stimulus avoids that by loading start addresses just
below FFFF and counts of 0 to 2, so each run ends in a few cycles. It then
reads the address and count back through the byte pointer to confirm where
each run stopped. A second instance in word mode receives the same host
traffic, with its port address doubled. It is also given odd port addresses,
which it must ignore.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH     = 4;
  localparam int CH_W    = $clog2(NCH);
  localparam int CNT_W   = 16;
  localparam int PAGE_W  = 8;
  localparam int BUS_W   = CNT_W + PAGE_W;
  localparam int OFF_W   = 4;

  localparam logic [OFF_W-1:0] OFF_STATUS = 4'd8;
  localparam logic [OFF_W-1:0] OFF_MASK   = 4'd10;
  localparam logic [OFF_W-1:0] OFF_MODE   = 4'd11;
  localparam logic [OFF_W-1:0] OFF_CLRPTR = 4'd12;

  typedef enum logic [1:0] {
    XT_VERIFY  = 2'b00,
    XT_TO_MEM  = 2'b01,
    XT_FROM_MEM = 2'b10,
    XT_RSVD    = 2'b11
  } xfer_e;

  localparam logic [1:0] KIND_CASCADE = 2'b11;
endpackage

// File: rtl/dma4_regif.sv
module dma4_regif
  import dma4_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           io_wr,
  input  logic           io_rd,
  input  logic [4:0]     io_addr,
  output logic [NCH-1:0] acc_addr,
  output logic [NCH-1:0] acc_cnt,
  output logic           hi_sel,
  output logic           mask_wr,
  output logic           mode_wr,
  output logic           stat_rd,
  output logic           clr_ptr
);
  logic [OFF_W-1:0] off;
  logic             aligned;
  logic             any_acc;
  logic             ptr_q;

  generate
    if (WORD_MODE) begin : g_word
      assign off     = io_addr[4:1];
      assign aligned = ~io_addr[0];
    end else begin : g_byte
      assign off     = io_addr[3:0];
      assign aligned = ~io_addr[4];
    end
  endgenerate

  wire acc = (io_wr | io_rd) & aligned;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign acc_addr[c] = acc && (off == OFF_W'(2*c));
    assign acc_cnt[c]  = acc && (off == OFF_W'(2*c+1));
  end

  assign mask_wr = io_wr & aligned & (off == OFF_MASK);
  assign mode_wr = io_wr & aligned & (off == OFF_MODE);
  assign clr_ptr = io_wr & aligned & (off == OFF_CLRPTR);
  assign stat_rd = io_rd & aligned & (off == OFF_STATUS);
  assign any_acc = |{acc_addr, acc_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= 1'b0;
    else if (clr_ptr)  ptr_q <= 1'b0;
    else if (any_acc)  ptr_q <= ~ptr_q;
  end
  assign hi_sel = ptr_q;

  assert_ptr_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr |=> !hi_sel);
  assert_ptr_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (any_acc && !clr_ptr) |=> (hi_sel != $past(hi_sel)));
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic             acc_addr,
  input  logic             acc_cnt,
  input  logic             hi_sel,
  input  logic [7:0]       wdata,
  input  logic             mode_wr,
  input  logic             mask_wr,
  input  logic             page_wr,
  input  logic [PAGE_W-1:0] page_val,
  input  logic             grant,
  input  logic             stat_clr,
  output logic [CNT_W-1:0] cur_addr,
  output logic [CNT_W-1:0] cur_cnt,
  output logic [PAGE_W-1:0] page,
  output logic             masked,
  output logic             tc,
  output logic             cascade,
  output xfer_e            xtype
);
  logic [1:0] kind_q;
  wire last = grant && (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      page     <= '0;
      masked   <= 1'b1;
      tc       <= 1'b0;
      kind_q   <= 2'b00;
      xtype    <= XT_VERIFY;
    end else begin
      if (wen && acc_addr) begin
        if (hi_sel) cur_addr[15:8] <= wdata;
        else        cur_addr[7:0]  <= wdata;
      end else if (grant) begin
        cur_addr <= cur_addr + 1'b1;
      end
      if (wen && acc_cnt) begin
        if (hi_sel) cur_cnt[15:8] <= wdata;
        else        cur_cnt[7:0]  <= wdata;
      end else if (grant) begin
        cur_cnt <= cur_cnt - 1'b1;
      end
      if (page_wr) page <= page_val;
      if (last)         masked <= 1'b1;
      else if (mask_wr) masked <= wdata[2];
      if (last)          tc <= 1'b1;
      else if (stat_clr) tc <= 1'b0;
      if (mode_wr) begin
        kind_q <= wdata[7:6];
        xtype  <= xfer_e'(wdata[3:2]);
      end
    end
  end
  assign cascade = (kind_q == KIND_CASCADE);

  assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc) |-> masked);
  assert_status_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !grant) |=> !tc);
endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    assert_gnt_onehot_R6: assert ($onehot0(gnt));
    assert_gnt_requested_R6: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [4:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic        pg_wr,
  input  logic [1:0]  pg_chan,
  input  logic [7:0]  pg_wdata,
  input  logic [3:0]  dreq,
  output logic [3:0]  dack,
  output logic [23:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        up_req,
  input  logic        up_ack
);
  logic [NCH-1:0] acc_addr, acc_cnt;
  logic           hi_sel, mask_wr, mode_wr, stat_rd, clr_ptr;

  logic [CNT_W-1:0]  ch_addr [NCH];
  logic [CNT_W-1:0]  ch_cnt  [NCH];
  logic [PAGE_W-1:0] ch_page [NCH];
  xfer_e             ch_xt   [NCH];
  logic [NCH-1:0]    masked, tc, casc;
  logic [NCH-1:0]    elig, gnt, creq, cgnt;

  dma4_regif #(.WORD_MODE(WORD_MODE)) u_regif (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .acc_addr(acc_addr), .acc_cnt(acc_cnt), .hi_sel(hi_sel), .mask_wr(mask_wr),
    .mode_wr(mode_wr), .stat_rd(stat_rd), .clr_ptr(clr_ptr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma4_chan u_chan (
      .clk(clk), .rst_n(rst_n), .wen(io_wr),
      .acc_addr(acc_addr[c]), .acc_cnt(acc_cnt[c]), .hi_sel(hi_sel),
      .wdata(io_wdata),
      .mode_wr(mode_wr && (io_wdata[CH_W-1:0] == CH_W'(c))),
      .mask_wr(mask_wr && (io_wdata[CH_W-1:0] == CH_W'(c))),
      .page_wr(pg_wr && (pg_chan == CH_W'(c))), .page_val(pg_wdata),
      .grant(gnt[c]), .stat_clr(stat_rd),
      .cur_addr(ch_addr[c]), .cur_cnt(ch_cnt[c]), .page(ch_page[c]),
      .masked(masked[c]), .tc(tc[c]), .cascade(casc[c]), .xtype(ch_xt[c])
    );
  end

  assign elig = dreq & ~masked & ~casc;
  assign creq = dreq & ~masked & casc;

  dma4_prio #(.N(NCH)) u_prio_xfer (.req(elig), .gnt(gnt));
  dma4_prio #(.N(NCH)) u_prio_casc (.req(creq), .gnt(cgnt));

  always_comb begin
    io_rdata = '0;
    if (stat_rd) io_rdata = {4'b0000, tc};
    for (int c = 0; c < NCH; c++) begin
      if (io_rd && acc_addr[c]) io_rdata = hi_sel ? ch_addr[c][15:8] : ch_addr[c][7:0];
      if (io_rd && acc_cnt[c])  io_rdata = hi_sel ? ch_cnt[c][15:8]  : ch_cnt[c][7:0];
    end
  end

  logic [CH_W-1:0] gidx;
  always_comb begin
    gidx = '0;
    for (int c = 0; c < NCH; c++) if (gnt[c]) gidx = CH_W'(c);
  end

  logic [BUS_W-1:0] next_addr;
  generate
    if (WORD_MODE) begin : g_wa
      assign next_addr = {ch_page[gidx][PAGE_W-1:1], ch_addr[gidx], 1'b0};
    end else begin : g_ba
      assign next_addr = {ch_page[gidx], ch_addr[gidx]};
    end
  endgenerate

  logic [NCH-1:0]   dack_q;
  logic [BUS_W-1:0] addr_q;
  logic             rd_q, wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dack_q <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      dack_q <= gnt;
      rd_q   <= (|gnt) && (ch_xt[gidx] == XT_FROM_MEM);
      wr_q   <= (|gnt) && (ch_xt[gidx] == XT_TO_MEM);
      if (|gnt) addr_q <= next_addr;
    end
  end

  assign up_req   = |creq;
  assign dack     = dack_q | (up_ack ? cgnt : '0);
  assign mem_addr = addr_q;
  assign mem_rd   = rd_q;
  assign mem_wr   = wr_q;

  assert_single_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack_q));
  assert_cascade_no_xfer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q & $past(casc)) == '0);
  assert_page_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dack_q != '0 && dack_q == $past(dack_q) && !$past(pg_wr, 2) && !$past(pg_wr))
      |-> (addr_q[23:17] == $past(addr_q[23:17])));
  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));
endmodule

// File: tb/dma4_ctrl_tb.sv
`timescale 1ns/1ps
module dma4_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        io_wr = 0, io_rd = 0, pg_wr = 0, up_ack = 0, w_odd = 0;
  logic [4:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0, pg_wdata = '0;
  logic [1:0]  pg_chan = '0;
  logic [3:0]  dreq = '0;
  logic [7:0]  rd_b, rd_w;
  logic [3:0]  dack_b, dack_w;
  logic [23:0] ma_b, ma_w;
  logic        mr_b, mw_b, mr_w, mw_w, ur_b, ur_w;
  wire  [4:0]  io_addr_w = {io_addr[3:0], w_odd};

  dma4_ctrl #(.WORD_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(rd_b), .pg_wr(pg_wr), .pg_chan(pg_chan),
    .pg_wdata(pg_wdata), .dreq(dreq), .dack(dack_b), .mem_addr(ma_b),
    .mem_rd(mr_b), .mem_wr(mw_b), .up_req(ur_b), .up_ack(up_ack));

  dma4_ctrl #(.WORD_MODE(1'b1)) u_dutw (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr_w),
    .io_wdata(io_wdata), .io_rdata(rd_w), .pg_wr(pg_wr), .pg_chan(pg_chan),
    .pg_wdata(pg_wdata), .dreq(dreq), .dack(dack_w), .mem_addr(ma_w),
    .mem_rd(mr_w), .mem_wr(mw_w), .up_req(ur_w), .up_ack(up_ack));

  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic hrd(input logic [4:0] a, output logic [7:0] vb, output logic [7:0] vw);
    @(negedge clk); io_addr = a; io_rd = 1; #1; vb = rd_b; vw = rd_w;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic pwr(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk); pg_chan = c; pg_wdata = d; pg_wr = 1;
    @(negedge clk); pg_wr = 0;
  endtask

  function automatic logic [23:0] wa(input logic [7:0] pg, input logic [15:0] a);
    return {pg[7:1], a, 1'b0};
  endfunction

  // sampled after the edge that registered the transfer (R6, R10, R11)
  task automatic xchk(input logic [3:0] ek, input logic [7:0] pg, input logic [15:0] a,
                      input logic er, input logic ew, input string tag);
    chk({28'b0, dack_b}, {28'b0, ek}, {tag, " dack byte"});
    chk({28'b0, dack_w}, {28'b0, ek}, {tag, " dack word"});
    if (ek != 0) begin
      chk({8'b0, ma_b}, {8'b0, pg, a}, {tag, " addr byte R10"});
      chk({8'b0, ma_w}, {8'b0, wa(pg, a)}, {tag, " addr word R11"});
      chk({30'b0, mr_b, mw_b}, {30'b0, er, ew}, {tag, " strobes R4"});
    end
  endtask

  typedef struct packed {
    logic [1:0] op;   // 0 write, 1 read and compare, 2 page write
    logic [4:0] a;
    logic [7:0] d;
  } vec_t;
  localparam int NV = 26;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 5'd8,  8'h00},  // R9 status zero after reset
    '{2'd0, 5'd12, 8'h5A},  // R2 clear pointer
    '{2'd0, 5'd0,  8'h34},  // R1 ch0 addr lo
    '{2'd0, 5'd0,  8'h12},  // R1 ch0 addr hi
    '{2'd0, 5'd1,  8'h02},  // R3 ch0 count lo -> 3 transfers
    '{2'd0, 5'd1,  8'h00},
    '{2'd0, 5'd12, 8'h00},
    '{2'd1, 5'd0,  8'h34},  // R1 read back low first
    '{2'd1, 5'd0,  8'h12},
    '{2'd1, 5'd1,  8'h02},
    '{2'd1, 5'd1,  8'h00},
    '{2'd0, 5'd2,  8'hFE},  // R3 ch1 addr FFFE
    '{2'd0, 5'd2,  8'hFF},
    '{2'd0, 5'd3,  8'h02},
    '{2'd0, 5'd3,  8'h00},
    '{2'd0, 5'd11, 8'h48},  // R4 ch0 single, read memory
    '{2'd0, 5'd11, 8'h45},  // R4 ch1 single, write memory
    '{2'd0, 5'd11, 8'hC2},  // R4 ch2 cascade
    '{2'd0, 5'd11, 8'h43},  // R4 ch3 verify
    '{2'd2, 5'd0,  8'h0A},
    '{2'd2, 5'd1,  8'h07},
    '{2'd0, 5'd12, 8'h00},  // R2 pointer mid-sequence
    '{2'd0, 5'd6,  8'h00},  // ch3 addr 0000
    '{2'd1, 5'd6,  8'h00},  // R1 hi byte of ch3 addr (pointer moved)
    '{2'd1, 5'd8,  8'h00},  // R5 nothing ran while masked
    '{2'd1, 5'd7,  8'h00}   // ch3 count low byte still 0 (R8 set-up)
  };

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] vb, vw;
    repeat (3) @(negedge clk);
    // reset state
    chk({28'b0, dack_b}, 32'h0, "R5 reset dack");
    chk({31'b0, ur_b}, 32'h0, "R12 reset up_req");
    chk({8'b0, ma_b}, 32'h0, "R6 reset mem_addr");
    rst_n = 1;
    @(negedge clk);

    foreach (TBL[i]) begin
      case (TBL[i].op)
        2'd0: hwr(TBL[i].a, TBL[i].d);
        2'd1: begin
          hrd(TBL[i].a, vb, vw);
          chk({24'b0, vb}, {24'b0, TBL[i].d}, $sformatf("R1/R3/R9 table %0d byte", i));
          chk({24'b0, vw}, {24'b0, TBL[i].d}, $sformatf("R1/R3/R9 table %0d word", i));
        end
        default: pwr(TBL[i].a[1:0], TBL[i].d);
      endcase
    end

    // R6 R7 R8: ch0 three transfers then auto mask
    hwr(5'd10, 8'h00);
    dreq = 4'b0001;
    @(negedge clk); xchk(4'b0001, 8'h0A, 16'h1234, 1, 0, "R6 ch0 #1");
    @(negedge clk); xchk(4'b0001, 8'h0A, 16'h1235, 1, 0, "R7 ch0 #2");
    @(negedge clk); xchk(4'b0001, 8'h0A, 16'h1236, 1, 0, "R7 ch0 #3");
    @(negedge clk); xchk(4'b0000, 8'h00, 16'h0000, 0, 0, "R8 ch0 stops after tc");
    dreq = 0;
    hrd(5'd8, vb, vw);
    chk({24'b0, vb}, 32'h01, "R9 status ch0 tc");
    hrd(5'd8, vb, vw);
    chk({24'b0, vb}, 32'h00, "R9 status cleared by read");
    hwr(5'd12, 8'h00);
    hrd(5'd0, vb, vw); chk({24'b0, vb}, 32'h37, "R7 addr lo after run");
    hrd(5'd0, vb, vw); chk({24'b0, vb}, 32'h12, "R7 addr hi after run");
    hrd(5'd1, vb, vw); chk({24'b0, vb}, 32'hFF, "R8 count wrapped lo");
    hrd(5'd1, vb, vw); chk({24'b0, vw}, 32'hFF, "R8 count wrapped hi");

    // R10: ch1 wraps inside its page
    hwr(5'd10, 8'h01);
    dreq = 4'b0010;
    @(negedge clk); xchk(4'b0010, 8'h07, 16'hFFFE, 0, 1, "R10 ch1 #1");
    @(negedge clk); xchk(4'b0010, 8'h07, 16'hFFFF, 0, 1, "R10 ch1 #2");
    @(negedge clk); xchk(4'b0010, 8'h07, 16'h0000, 0, 1, "R10 ch1 wrap");
    dreq = 0;
    hrd(5'd8, vb, vw);
    chk({24'b0, vw}, 32'h02, "R9 status ch1 tc");

    // R6 priority: ch0 and ch1 request together, count 0 each
    hwr(5'd12, 8'h00); hwr(5'd1, 8'h00); hwr(5'd1, 8'h00);
    hwr(5'd3, 8'h00);  hwr(5'd3, 8'h00);
    hwr(5'd10, 8'h00); hwr(5'd10, 8'h01);
    dreq = 4'b0011;
    @(negedge clk); xchk(4'b0001, 8'h0A, 16'h1237, 1, 0, "R6 lowest channel wins");
    @(negedge clk); xchk(4'b0010, 8'h07, 16'h0001, 0, 1, "R6 next channel after mask");
    @(negedge clk); xchk(4'b0000, 8'h00, 16'h0000, 0, 0, "R8 both masked");
    dreq = 0;
    hrd(5'd8, vb, vw);
    chk({24'b0, vb}, 32'h03, "R9 both tc bits");

    // R4 verify type on ch3, R5 masked channel ignored
    hwr(5'd10, 8'h03);
    dreq = 4'b1000;
    @(negedge clk); xchk(4'b1000, 8'h00, 16'h0000, 0, 0, "R4 verify no strobe");
    repeat (3) begin
      @(negedge clk); xchk(4'b0000, 8'h00, 16'h0000, 0, 0, "R5 masked ch3 ignored");
    end
    dreq = 0;

    // R12 cascade
    hwr(5'd10, 8'h02);
    dreq = 4'b0100; #1;
    chk({31'b0, ur_b}, 32'h1, "R12 up_req");
    chk({28'b0, dack_b}, 32'h0, "R12 no dack without up_ack");
    up_ack = 1; #1;
    chk({28'b0, dack_w}, 32'h4, "R12 dack follows up_ack");
    @(negedge clk);
    chk({30'b0, mr_b, mw_b}, 32'h0, "R12 no strobes");
    hwr(5'd10, 8'h06); #1;
    chk({31'b0, ur_b}, 32'h0, "R5 masked cascade drops up_req");
    chk({28'b0, dack_b}, 32'h0, "R5 masked cascade no dack");
    dreq = 0; up_ack = 0;

    // R3 odd host addresses ignored in word mode
    hwr(5'd12, 8'h00);
    w_odd = 1; hwr(5'd1, 8'h55); hwr(5'd1, 8'h66); w_odd = 0;
    hwr(5'd12, 8'h00);
    hrd(5'd1, vb, vw);
    chk({24'b0, vb}, 32'h55, "R3 byte mode took write");
    chk({24'b0, vw}, 32'hFF, "R3 word odd write ignored lo");
    hrd(5'd1, vb, vw);
    chk({24'b0, vw}, 32'hFF, "R3 word odd write ignored hi");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule